// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Block

This block is the software-visible control and status front end of a bus-mastering disk DMA engine. A host reaches it over a small synchronous register bus with a 3-bit byte offset and a 32-bit data word. Through that bus the host loads the base address of the descriptor table, picks the transfer direction, and then sets a start bit. The register outputs are connected to a separate datapath, which fetches the descriptors and moves the data. That datapath reports back on three lines: completion, an engine error, and a forwarded device interrupt.

The status byte holds several kinds of bit. Bit 0 (transfer active) is read-only and is maintained by the hardware. Bits 1 (error) and 2 (interrupt) are sticky, and software clears them by writing a 1. Bits 5 and 6 are plain read/write capability flags, one for each of two drives. Software can therefore clear both event flags by writing back the value it read with bits 1 and 2 forced to 1, and this leaves every other bit as it was.

A transfer finished cleanly when the low three status bits read binary 100: interrupt seen, no error, and no longer active. The host interrupt line follows the interrupt flag and stays high until software clears that flag.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every register reads zero, and the `xfer_start_o`, `xfer_dir_o`, `tbl_base_o` and `host_irq_o` outputs are all low.
- R2: The command register sits at offset 0. Bit 0 is start and bit 3 is direction (1 means device to memory). The other bits are not stored and read as 0. `xfer_start_o` and `xfer_dir_o` take the new value on the clock edge of the write.
- R3: Status bit 0 (active) sets when a command write changes start from 0 to 1. It clears when `eng_done_i` or `eng_err_i` is high, or when a command write changes start from 1 to 0.
- R4: Status bit 1 (error) sets on any cycle in which `eng_err_i` is high. Status bit 2 (interrupt) sets on any cycle in which `dev_irq_i` is high. Both bits hold their value after the input falls.
- R5: The status register sits at offset 2. Writing 1 to bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. If the set event and the clearing write fall in the same cycle, the bit stays set.
- R6: Status bits 5 (drive 0) and 6 (drive 1) are read/write. Writes to status bits 0, 3, 4 and 7 have no effect. Bits 3, 4 and 7 always read 0.
- R7: The descriptor table base sits at offset 4 and is 32 bits wide. Its two low bits always read 0, and `tbl_base_o` carries the same value as the register.
- R8: While status bit 0 is set, writes to the table base are ignored.
- R9: `host_irq_o` equals status bit 2 and stays high until software clears that bit.
- R10: When a transfer completes with `eng_done_i` and then `dev_irq_i`, the low three status bits read binary 100.
- R11: `bus_rdata` is registered. It carries the register selected by `bus_addr` one clock after the address is presented. Offsets 1, 3, 5, 6 and 7 read 0. The narrow registers return their value on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_irq_i | input | 1 | Device interrupt forwarded by the datapath |
| eng_err_i | input | 1 | Engine error report |
| eng_done_i | input | 1 | Engine completion report |
| xfer_start_o | output | 1 | Start level to the datapath |
| xfer_dir_o | output | 1 | Direction to the datapath, 1 = device to memory |
| tbl_base_o | output | 32 | Descriptor table base address |
| host_irq_o | output | 1 | Interrupt to the host |

## Verification
A write, or an event pulse on the datapath inputs, is taken on a single rising edge. Every register output and `host_irq_o` therefore shows the result at the next falling edge, and the bench compares those outputs directly at that point. A read is due one edge after its address is driven. The driver records each read in a queue, tagged with the cycle in which it is due. The monitor pops each entry on the falling edge of its due cycle and compares it with `bus_rdata`. This keeps every comparison half a period away from the edge that produced the value.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // byte offsets on the register bus
  localparam int OFS_CMD  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PTR  = 4;
  // command bit positions
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  // status bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  // number of alignment bits forced to zero in the table pointer
  localparam int PTR_ALIGN = 2;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_start,
  input  logic wr_dir,
  output logic start_q,
  output logic dir_q,
  output logic start_rise,
  output logic start_fall
);
  always_comb begin
    start_rise = wr_en & wr_start & ~start_q;
    start_fall = wr_en & ~wr_start & start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (wr_en) begin
      start_q <= wr_start;
      dir_q   <= wr_dir;
    end
  end
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg #(
  parameter int NUM_DRV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_err_clr,
  input  logic               wr_irq_clr,
  input  logic [NUM_DRV-1:0] wr_cap,
  input  logic               start_rise,
  input  logic               start_fall,
  input  logic               eng_done,
  input  logic               eng_err,
  input  logic               dev_irq,
  output logic               active_q,
  output logic               err_q,
  output logic               irq_q,
  output logic [NUM_DRV-1:0] cap_q
);
  // active: set on start edge, cleared by completion, error or stop
  always_ff @(posedge clk) begin
    if (rst)                                     active_q <= 1'b0;
    else if (start_rise)                         active_q <= 1'b1;
    else if (eng_done | eng_err | start_fall)    active_q <= 1'b0;
  end

  // sticky event flags, set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (eng_err)                   err_q <= 1'b1;
      else if (wr_en && wr_err_clr)  err_q <= 1'b0;
      if (dev_irq)                   irq_q <= 1'b1;
      else if (wr_en && wr_irq_clr)  irq_q <= 1'b0;
    end
  end

  // per-drive capability flags
  for (genvar d = 0; d < NUM_DRV; d++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)        cap_q[d] <= 1'b0;
      else if (wr_en) cap_q[d] <= wr_cap[d];
    end
  end
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               lock,
  input  logic [PTR_W-1:ALIGN] wr_val,
  output logic [PTR_W-1:0]   ptr_o
);
  logic [PTR_W-1:ALIGN] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)                 ptr_q <= '0;
    else if (wr_en && !lock) ptr_q <= wr_val;
  end

  assign ptr_o = {ptr_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int NUM_DRV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_irq_i,
  input  logic              eng_err_i,
  input  logic              eng_done_i,
  output logic              xfer_start_o,
  output logic              xfer_dir_o,
  output logic [DATA_W-1:0] tbl_base_o,
  output logic              host_irq_o
);
  import bmdma_pkg::*;

  localparam int BYTE_W = 8;

  logic sel_cmd, sel_stat, sel_ptr;
  logic start_rise, start_fall;
  logic active_w, err_w, irq_w;
  logic [NUM_DRV-1:0] cap_w;
  logic [BYTE_W-1:0]  cmd_byte, stat_byte;
  logic [DATA_W-1:0]  rd_mux;

  assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_ptr  = (bus_addr == ADDR_W'(OFS_PTR));

  bmdma_cmd_reg u_cmd (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr & sel_cmd),
    .wr_start   (bus_wdata[CMD_START]),
    .wr_dir     (bus_wdata[CMD_DIR]),
    .start_q    (xfer_start_o),
    .dir_q      (xfer_dir_o),
    .start_rise (start_rise),
    .start_fall (start_fall)
  );

  bmdma_status_reg #(.NUM_DRV(NUM_DRV)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr & sel_stat),
    .wr_err_clr (bus_wdata[ST_ERR]),
    .wr_irq_clr (bus_wdata[ST_IRQ]),
    .wr_cap     (bus_wdata[ST_CAP0 +: NUM_DRV]),
    .start_rise (start_rise),
    .start_fall (start_fall),
    .eng_done   (eng_done_i),
    .eng_err    (eng_err_i),
    .dev_irq    (dev_irq_i),
    .active_q   (active_w),
    .err_q      (err_w),
    .irq_q      (irq_w),
    .cap_q      (cap_w)
  );

  bmdma_ptr_reg #(.PTR_W(DATA_W), .ALIGN(PTR_ALIGN)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr & sel_ptr),
    .lock   (active_w),
    .wr_val (bus_wdata[DATA_W-1:PTR_ALIGN]),
    .ptr_o  (tbl_base_o)
  );

  always_comb begin
    cmd_byte = '0;
    cmd_byte[CMD_START] = xfer_start_o;
    cmd_byte[CMD_DIR]   = xfer_dir_o;
    stat_byte = '0;
    stat_byte[ST_ACT] = active_w;
    stat_byte[ST_ERR] = err_w;
    stat_byte[ST_IRQ] = irq_w;
    stat_byte[ST_CAP0 +: NUM_DRV] = cap_w;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_cmd)       rd_mux[BYTE_W-1:0] = cmd_byte;
    else if (sel_stat) rd_mux[BYTE_W-1:0] = stat_byte;
    else if (sel_ptr)  rd_mux = tbl_base_o;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign host_irq_o = irq_w;
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              dev_irq_i,
  input logic              eng_done_i,
  input logic              active,
  input logic              xfer_start_o,
  input logic              host_irq_o,
  input logic [DATA_W-1:0] tbl_base_o
);
  import bmdma_pkg::*;

  logic wr_cmd, wr_stat, wr_ptr;
  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ptr  = bus_wr && (bus_addr == ADDR_W'(OFS_PTR));

  AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> (xfer_start_o == $past(bus_wdata[CMD_START]))); // R2

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (eng_done_i && !wr_cmd) |=> !active); // R3

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (rst)
    dev_irq_i |=> host_irq_o); // R4

  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[ST_IRQ] && !dev_irq_i) |=> !host_irq_o); // R5

  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!wr_ptr || active) |=> $stable(tbl_base_o)); // R8
endmodule

bind bmdma_regs bmdma_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .dev_irq_i    (dev_irq_i),
  .eng_done_i   (eng_done_i),
  .active       (active_w),
  .xfer_start_o (xfer_start_o),
  .host_irq_o   (host_irq_o),
  .tbl_base_o   (tbl_base_o)
);

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_irq_i = 1'b0;
  logic        eng_err_i = 1'b0;
  logic        eng_done_i = 1'b0;
  logic        xfer_start_o, xfer_dir_o, host_irq_o;
  logic [31:0] tbl_base_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int unsigned exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  bmdma_regs dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq_i(dev_irq_i),
    .eng_err_i(eng_err_i), .eng_done_i(eng_done_i),
    .xfer_start_o(xfer_start_o), .xfer_dir_o(xfer_dir_o),
    .tbl_base_o(tbl_base_o), .host_irq_o(host_irq_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares reads in the cycle they fall due
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      void'(due_q.pop_front());
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    exp_q.push_back(exp); due_q.push_back(cyc + 1); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 start", {31'd0, xfer_start_o}, 0);
    check("R1 irq", {31'd0, host_irq_o}, 0);
    check("R1 base", tbl_base_o, 0);
    rd(3'd0, 0, "R1 cmd");
    rd(3'd2, 0, "R1 status");
    rd(3'd4, 0, "R1 pointer");
    // R7 pointer alignment
    wr(3'd4, 32'h1234_5677);
    check("R7 base out", tbl_base_o, 32'h1234_5674);
    rd(3'd4, 32'h1234_5674, "R7 pointer read");
    // R2 command: only start and dir stored
    wr(3'd0, 32'h0000_00F7);
    check("R2 start_o", {31'd0, xfer_start_o}, 1);
    check("R2 dir_o", {31'd0, xfer_dir_o}, 0);
    rd(3'd0, 32'h01, "R2 cmd read");
    rd(3'd2, 32'h01, "R3 active set");
    // R8 pointer locked while active
    wr(3'd4, 32'hAAAA_AAA8);
    rd(3'd4, 32'h1234_5674, "R8 pointer locked");
    // R3 done clears active
    eng_done_i = 1'b1; @(negedge clk); eng_done_i = 1'b0;
    rd(3'd2, 32'h00, "R3 done clears");
    check("R3 start kept", {31'd0, xfer_start_o}, 1);
    // R4 / R9 / R10 interrupt and clean status
    dev_irq_i = 1'b1; @(negedge clk); dev_irq_i = 1'b0;
    check("R9 irq high", {31'd0, host_irq_o}, 1);
    rd(3'd2, 32'h04, "R10 clean status");
    check("R4 irq held", {31'd0, host_irq_o}, 1);
    // R5 / R6 clear irq and set caps
    wr(3'd2, 32'h64);
    check("R9 irq cleared", {31'd0, host_irq_o}, 0);
    rd(3'd2, 32'h60, "R5 w1c with caps");
    wr(3'd2, 32'h9F);
    rd(3'd2, 32'h00, "R6 ro bits ignored");
    wr(3'd2, 32'h20);
    rd(3'd2, 32'h20, "R6 cap drive0");
    // R2 stop and direction
    wr(3'd0, 32'h08);
    check("R2 stop", {31'd0, xfer_start_o}, 0);
    check("R2 dir", {31'd0, xfer_dir_o}, 1);
    rd(3'd0, 32'h08, "R2 cmd read dir");
    // R3 / R4 error ends transfer
    wr(3'd0, 32'h09);
    rd(3'd2, 32'h21, "R3 restart");
    eng_err_i = 1'b1; @(negedge clk); eng_err_i = 1'b0;
    rd(3'd2, 32'h22, "R4 error set");
    check("R4 no irq", {31'd0, host_irq_o}, 0);
    // R11 unmapped offsets
    rd(3'd1, 0, "R11 offset1");
    rd(3'd6, 0, "R11 offset6");
    // R5 clear error
    wr(3'd2, 32'h26);
    rd(3'd2, 32'h20, "R5 error cleared");
    // R3 stop clears active
    wr(3'd0, 32'h08);
    wr(3'd0, 32'h09);
    rd(3'd2, 32'h21, "R3 active again");
    wr(3'd0, 32'h08);
    rd(3'd2, 32'h20, "R3 stop clears");
    // R5 set wins over clear
    dev_irq_i = 1'b1;
    wr(3'd2, 32'h24);
    dev_irq_i = 1'b0;
    check("R5 set priority", {31'd0, host_irq_o}, 1);
    wr(3'd2, 32'h24);
    check("R5 later clear", {31'd0, host_irq_o}, 0);
    // R7 / R8 pointer writable when idle
    wr(3'd4, 32'hFFFF_FFFF);
    check("R8 unlocked", tbl_base_o, 32'hFFFF_FFFC);
    rd(3'd4, 32'hFFFF_FFFC, "R7 pointer max");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule